// File: doc/BRIEF.md
# 8-bit Timer with Two Compare Channels

This block is an 8-bit timer/counter for a small microcontroller-style peripheral. It advances on timer ticks, which are single-cycle strobes picked by a clock-select input from a set of prescaled tick sources. It can also be stopped. Four operating modes set how the counter runs:

- up with a top value of 0xFF;
- up with the top value taken from compare channel A;
- up/down with a top value of 0xFF;
- up/down with the top value taken from compare channel A.

Each of the two compare channels keeps a buffered value and an active value. The active value is checked against the counter on every timer tick. A match sets that channel's flag and updates its waveform pin.

Software uses a small register interface. Through it, software reaches the count, both compare buffers, a flag register that is cleared by writing ones, and an interrupt mask. The interrupt output is high while any flag is set together with its mask bit.

The counting direction is held in a two-state machine:

- `DIR_UP` moves to `DIR_DOWN` on a step whose new count reaches or passes TOP, in an up/down mode.
- `DIR_DOWN` moves to `DIR_UP` on a step whose new count is BOTTOM (0x00).
- `DIR_DOWN` also moves to `DIR_UP` on any step made in an up-only mode.

A "step" is a timer tick that does not coincide with a write to the count register.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count, both compare buffers, the flags and the mask are 0x00, both waveform pins are low and irq is low.
- R2: clk_sel 0 stops the counter. clk_sel k (1..4) advances it only on strobes of tick_src[k-1]. clk_sel values above 4 also stop it.
- R3: In mode 0 the counter counts up, and the step after 0xFF gives 0x00. The step whose new count is 0xFF sets flag bit 0 (overflow). Compare writes take effect on the active value at once.
- R4: In mode 1 the counter counts up to TOP, which is active compare A. The step from a count at or above TOP gives 0x00, and on that step both buffered compare values move into the active registers. A step whose new count equals TOP sets flag bit 0.
- R5: In modes 2 (TOP=0xFF) and 3 (TOP=active compare A) the counter runs 0,1,…,TOP,TOP-1,…,0,1,… A step whose new count is 0x00 sets flag bit 0. Buffered compare values move to the active registers on the step taken from count 0x00.
- R6: A step taken while the count equals a channel's active compare value is a match. A match on channel A sets flag bit 1, and a match on channel B sets flag bit 2.
- R7: In modes 0 and 1 a match toggles that channel's waveform pin. In modes 2 and 3 a match drives the pin low when that step goes up and high when it goes down. Pins change only on a match.
- R8: Writing the flag register (address 3) clears each bit written as one and leaves bits written as zero. A set in the same cycle wins over the clear.
- R9: irq is high exactly when some flag bit and the same bit of the mask register (address 4) are both one.
- R10: A write to the count register (address 0) loads the count. It cancels a tick in the same cycle, and it blocks any match on the next step.
- R11: Reads are combinational. Address 0 returns the count, 1 and 2 return the compare A and B buffers, 3 the flags and 4 the mask; other addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_src | input | 4 | Prescaled single-cycle tick strobes |
| clk_sel | input | 3 | Tick source select, 0 = stopped |
| mode | input | 2 | Operating mode 0..3 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| irq | output | 1 | Masked interrupt request |

## Verification
Every tick-driven result is due after the one clock edge that samples the strobe: the count, the direction, the flags, the waveform pins and the compare loads all move on that edge. A register write takes effect at the edge that ends its write cycle. irq and read data follow combinationally from the registers. The bench drives each strobe or write for exactly one cycle starting at a falling edge. It queues its expectations only after the following falling edge, so every comparison lands half a period after the edge that produced the result.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_UP_A   = 2'd1,
        MODE_UD_MAX = 2'd2,
        MODE_UD_A   = 2'd3
    } tmr_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_e;

    localparam int ADDR_W    = 3;
    localparam int NUM_CH    = 2;
    localparam int NUM_FLAGS = 3;
    localparam int FLAG_OVF  = 0;
    localparam int FLAG_CMPA = 1;
    localparam int FLAG_CMPB = 2;

    localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMPA  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMPB  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_MASK  = 3'd4;
endpackage

// File: rtl/tmr_tick_select.sv
`timescale 1ns/1ps
module tmr_tick_select #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 3
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src,
    output logic               tick
);
    // code 0 and codes past the last source select nothing
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                tick = src[i];
            end
        end
    end
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  tmr_mode_e     mode,
    input  logic [CW-1:0] top_a,
    output logic [CW-1:0] count,
    output dir_state_e    dir,
    output logic          updown,
    output logic          step,
    output logic          blocked,
    output logic          load_evt,
    output logic          ovf_evt
);
    localparam logic [CW-1:0] CNT_MAX    = '1;
    localparam logic [CW-1:0] CNT_BOTTOM = '0;

    logic [CW-1:0] top;
    logic [CW-1:0] nxt;
    dir_state_e    dir_nxt;

    assign updown = (mode == MODE_UD_MAX) || (mode == MODE_UD_A);
    assign top    = ((mode == MODE_UP_A) || (mode == MODE_UD_A)) ? top_a : CNT_MAX;
    assign step   = tick && !cnt_wr;

    // next count and next direction state
    always_comb begin
        nxt     = count;
        dir_nxt = dir;
        if (!updown) begin
            nxt     = (count >= top) ? CNT_BOTTOM : count + 1'b1;
            dir_nxt = DIR_UP;
        end else begin
            unique case (dir)
                DIR_UP: begin
                    if ((count >= top) && (count != CNT_BOTTOM)) begin
                        nxt     = count - 1'b1;
                        dir_nxt = DIR_DOWN;
                    end else begin
                        nxt = count + 1'b1;
                        if (nxt >= top) begin
                            dir_nxt = DIR_DOWN;
                        end
                    end
                end
                DIR_DOWN: begin
                    if (count == CNT_BOTTOM) begin
                        nxt     = count + 1'b1;
                        dir_nxt = DIR_UP;
                    end else begin
                        nxt = count - 1'b1;
                        if (nxt == CNT_BOTTOM) begin
                            dir_nxt = DIR_UP;
                        end
                    end
                end
                default: begin
                    nxt     = count;
                    dir_nxt = DIR_UP;
                end
            endcase
        end
    end

    // direction state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= DIR_UP;
        end else if (step) begin
            dir <= dir_nxt;
        end
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CNT_BOTTOM;
        end else if (cnt_wr) begin
            count <= cnt_wdata;
        end else if (step) begin
            count <= nxt;
        end
    end

    // match blocking after a count write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked <= 1'b0;
        end else if (cnt_wr) begin
            blocked <= 1'b1;
        end else if (step) begin
            blocked <= 1'b0;
        end
    end

    // event outputs
    always_comb begin
        load_evt = step && (updown ? (count == CNT_BOTTOM) : (count >= top));
        ovf_evt  = step && (updown ? (nxt == CNT_BOTTOM) : (nxt == top));
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count));

    assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_UP_A && count < top_a) |=> (count == $past(count) + 1'b1));

    assert_down_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && updown && dir == DIR_DOWN && count != CNT_BOTTOM) |=> (count == $past(count) - 1'b1));

    assert_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(cnt_wdata)));
endmodule

// File: rtl/tmr_cmp_channel.sv
`timescale 1ns/1ps
module tmr_cmp_channel
    import tmr_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          direct,
    input  logic          load,
    input  logic          step,
    input  logic          blocked,
    input  logic [CW-1:0] count,
    input  logic          updown,
    input  dir_state_e    dir,
    output logic [CW-1:0] buf_val,
    output logic [CW-1:0] active,
    output logic          match,
    output logic          wave
);
    assign match = step && !blocked && (count == active);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_val <= '0;
        end else if (wr) begin
            buf_val <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (wr && direct) begin
            active <= wdata;
        end else if (load) begin
            active <= buf_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else if (match) begin
            if (!updown) begin
                wave <= ~wave;
            end else begin
                wave <= (dir == DIR_DOWN);
            end
        end
    end

    assert_wave_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(wave));
endmodule

// File: rtl/tick_cmp_timer.sv
`timescale 1ns/1ps
module tick_cmp_timer
    import tmr_pkg::*;
#(
    parameter int CW      = 8,
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic [SEL_W-1:0]   clk_sel,
    input  logic [1:0]         mode,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CW-1:0]      reg_wdata,
    output logic [CW-1:0]      reg_rdata,
    output logic               wave_a,
    output logic               wave_b,
    output logic               irq
);
    logic                 tick;
    logic                 cnt_wr;
    logic [CW-1:0]        count;
    dir_state_e           dir;
    logic                 updown;
    logic                 step;
    logic                 blocked;
    logic                 load_evt;
    logic                 ovf_evt;
    tmr_mode_e            mode_e;
    logic [CW-1:0]        buf_val [NUM_CH];
    logic [CW-1:0]        active  [NUM_CH];
    logic [NUM_CH-1:0]    match;
    logic [NUM_CH-1:0]    wave;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] mask;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;

    assign mode_e = tmr_mode_e'(mode);
    assign cnt_wr = reg_wr && (reg_addr == ADDR_COUNT);

    tmr_tick_select #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
        .sel (clk_sel),
        .src (tick_src),
        .tick(tick)
    );

    tmr_count_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_wr   (cnt_wr),
        .cnt_wdata(reg_wdata),
        .mode     (mode_e),
        .top_a    (active[0]),
        .count    (count),
        .dir      (dir),
        .updown   (updown),
        .step     (step),
        .blocked  (blocked),
        .load_evt (load_evt),
        .ovf_evt  (ovf_evt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_cmp_channel #(.CW(CW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (reg_wr && (reg_addr == ADDR_CMPA + ADDR_W'(c))),
            .wdata  (reg_wdata),
            .direct (mode_e == MODE_FREE),
            .load   (load_evt),
            .step   (step),
            .blocked(blocked),
            .count  (count),
            .updown (updown),
            .dir    (dir),
            .buf_val(buf_val[c]),
            .active (active[c]),
            .match  (match[c]),
            .wave   (wave[c])
        );

        assert_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_CMPA + ADDR_W'(c) && mode_e == MODE_FREE)
            |=> (active[c] == $past(reg_wdata)));
    end

    assign wave_a = wave[0];
    assign wave_b = wave[1];

    // flag and mask registers
    assign set_vec = {match[1], match[0], ovf_evt};
    assign clr_vec = (reg_wr && reg_addr == ADDR_FLAGS) ? reg_wdata[NUM_FLAGS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (reg_wr && reg_addr == ADDR_MASK) begin
            mask <= reg_wdata[NUM_FLAGS-1:0];
        end
    end

    assign irq = |(flags & mask);

    always_comb begin
        unique case (reg_addr)
            ADDR_COUNT: reg_rdata = count;
            ADDR_CMPA:  reg_rdata = buf_val[0];
            ADDR_CMPB:  reg_rdata = buf_val[1];
            ADDR_FLAGS: reg_rdata = CW'(flags);
            ADDR_MASK:  reg_rdata = CW'(mask);
            default:    reg_rdata = '0;
        endcase
    end

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match[0] |=> flags[FLAG_CMPA]);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_FLAGS && reg_wdata[FLAG_OVF] && !ovf_evt) |=> !flags[FLAG_OVF]);

    assert_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> !(match[0] || match[1]));
endmodule

// File: tb/tick_cmp_timer_test.sv
`timescale 1ns/1ps
module tick_cmp_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tick_src = '0;
    logic [2:0] clk_sel = '0;
    logic [1:0] mode = '0;
    logic       reg_wr = 1'b0;
    logic [2:0] drv_addr = '0;
    logic [2:0] mon_addr = '0;
    logic       mon_sel = 1'b0;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       wave_a, wave_b, irq;

    int errors = 0;
    int checks = 0;
    int pushed = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    // kind 0..4: register address, 5: {wave_b, wave_a}, 6: irq
    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    assign reg_addr = mon_sel ? mon_addr : drv_addr;

    always #2.5 clk = ~clk;

    tick_cmp_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .clk_sel(clk_sel),
        .mode(mode), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
    );

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            exp_t it;
            logic [7:0] obs;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            if (it.kind < 5) begin
                mon_addr = 3'(it.kind);
                mon_sel  = 1'b1;
                #0.5;
                obs = reg_rdata;
                mon_sel = 1'b0;
            end else if (it.kind == 5) begin
                obs = {6'd0, wave_b, wave_a};
            end else begin
                obs = {7'd0, irq};
            end
            checks++;
            if (obs !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%02h expected=%02h", it.req, obs, it.exp);
            end
            done_cnt++;
        end
    end

    task automatic expect_item(input int kind, input logic [7:0] exp, input string req);
        exp_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb_q.push_back(it);
        pushed++;
        wait (done_cnt == pushed);
    endtask

    task automatic pulse(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_src[idx] = 1'b1;
            @(negedge clk);
            tick_src = '0;
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        drv_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_item(0, 8'h00, "R1 count");
        expect_item(3, 8'h00, "R1 flags");
        expect_item(5, 8'h00, "R1 waves");
        expect_item(6, 8'h00, "R1 irq");
        expect_item(1, 8'h00, "R1 cmp A");

        // mode 0, compares take effect at once
        clk_sel = 3'd1;
        reg_write(3'd1, 8'h80);
        reg_write(3'd2, 8'h90);
        expect_item(1, 8'h80, "R11 cmp A readback");
        expect_item(7, 8'h00, "R11 unused address");
        pulse(1, 3);
        expect_item(0, 8'h00, "R2 other source ignored");
        pulse(0, 3);
        expect_item(0, 8'h03, "R2 selected source counts");
        clk_sel = 3'd0;
        pulse(0, 2);
        expect_item(0, 8'h03, "R2 stopped");
        clk_sel = 3'd7;
        pulse(0, 2);
        expect_item(0, 8'h03, "R2 out-of-range select");
        clk_sel = 3'd1;

        // wrap and overflow in mode 0
        reg_write(3'd0, 8'hFD);
        pulse(0, 2);
        expect_item(3, 8'h01, "R3 overflow at MAX");
        expect_item(0, 8'hFF, "R3 count MAX");
        pulse(0, 1);
        expect_item(0, 8'h00, "R3 wrap to BOTTOM");
        reg_write(3'd3, 8'h01);
        expect_item(3, 8'h00, "R8 clear by one");

        // match in mode 0
        reg_write(3'd0, 8'h7F);
        pulse(0, 2);
        expect_item(3, 8'h02, "R6 match A flag");
        expect_item(5, 8'h01, "R7 toggle A");
        expect_item(6, 8'h00, "R9 masked off");
        reg_write(3'd4, 8'h02);
        expect_item(6, 8'h01, "R9 mask enables irq");
        reg_write(3'd3, 8'h02);
        expect_item(6, 8'h00, "R9 irq after clear");

        // write blocks the next match
        reg_write(3'd0, 8'h90);
        pulse(0, 1);
        expect_item(3, 8'h00, "R10 match blocked");
        expect_item(0, 8'h91, "R10 count after write");
        reg_write(3'd0, 8'h8F);
        pulse(0, 2);
        expect_item(3, 8'h04, "R6 match B flag");
        expect_item(5, 8'h03, "R7 toggle B");
        reg_write(3'd3, 8'h00);
        expect_item(3, 8'h04, "R8 zero leaves flag");
        reg_write(3'd3, 8'h04);
        reg_write(3'd4, 8'h00);

        // mode 1, buffered compare A as TOP
        mode = 2'd1;
        reg_write(3'd1, 8'h05);
        expect_item(1, 8'h05, "R11 buffered readback");
        pulse(0, 1);
        expect_item(0, 8'h00, "R4 wrap above TOP");
        reg_write(3'd1, 8'h03);
        pulse(0, 5);
        expect_item(0, 8'h05, "R4 old TOP still active");
        pulse(0, 1);
        expect_item(0, 8'h00, "R4 wrap at TOP");
        pulse(0, 8);
        expect_item(0, 8'h00, "R4 new TOP loaded");
        expect_item(5, 8'h02, "R7 waves after mode 1");
        reg_write(3'd3, 8'h07);

        // mode 3, up/down with TOP from A
        mode = 2'd3;
        reg_write(3'd2, 8'h01);
        pulse(0, 2);
        expect_item(5, 8'h00, "R7 B low on rising match");
        pulse(0, 1);
        expect_item(0, 8'h03, "R5 reached TOP");
        pulse(0, 1);
        expect_item(0, 8'h02, "R5 turned down");
        expect_item(5, 8'h01, "R7 A high on falling match");
        pulse(0, 2);
        expect_item(0, 8'h00, "R5 reached BOTTOM");
        expect_item(3, 8'h07, "R5 overflow at BOTTOM");
        expect_item(5, 8'h03, "R7 B high on falling match");
        pulse(0, 1);
        expect_item(0, 8'h01, "R5 turned up");
        clk_sel = 3'd2;
        pulse(1, 1);
        expect_item(0, 8'h02, "R2 second source");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule